// File: doc/BRIEF.md
# Optical port carrier modulator

This block sits between a serial transmitter and the two pins of an infrared or optical link. On the transmit side it can chop the outgoing serial bits with a carrier of about 38 kHz, which is divided down from the system clock. A low serial bit becomes a train of short low pulses and a high bit keeps the pin at its high idle level. The low share of each carrier period can be set to one half, a quarter, an eighth or a sixteenth. While the brownout input is asserted, the carrier is suppressed even if modulation is enabled. Once modulation is applied, the transmit signal can be inverted for LEDs wired either way.

The transmit pin can also carry one of three other sources in place of the optical serial stream: a general-purpose output bit or one of two pulse outputs. On the receive side the pin passes through a synchronizer and an optional inverter to the serial receiver. The receive pin can also be released so that it serves as a general-purpose input. All configuration is presented as static input bits. The serial transmitter and receiver themselves are outside this block.

Top module: `optport_mod`

## Requirements
- R1: While reset is asserted and right after it is released, `tx_pin` is 1 and `ser_rx` is 1 when `rx_inv` is 0.
- R2: With modulation off (`mod_en`=0) and `tx_sel`=00 (optical serial), `tx_pin` equals `ser_tx ^ tx_inv` one clock after the input is sampled.
- R3: The carrier period is PERIOD_CYC = CLK_HZ / CARRIER_HZ clocks. With modulation active and `ser_tx`=0, the pin is low for the first L clocks of every period and high for the remaining PERIOD_CYC-L clocks.
- R4: `duty_sel` gives L = PERIOD_CYC>>1 for 00, PERIOD_CYC>>2 for 01, PERIOD_CYC>>3 for 10 and PERIOD_CYC>>4 for 11.
- R5: While `ser_tx`=1, the optical serial output stays high (before inversion) whether modulation is on or off.
- R6: While `brownout`=1, modulation is inactive and the pin follows `ser_tx ^ tx_inv` as in R2.
- R7: The carrier phase restarts whenever modulation is inactive. In the first clock in which `mod_en`=1 and `brownout`=0 are sampled, the output starts a full low window of L clocks.
- R8: `tx_inv`=1 inverts the optical serial output after modulation, so a carrier burst drives the pin high and idle drives it low.
- R9: `tx_sel` routes the registered pin as follows: 00 gives the optical serial output, 01 gives `gpio_out`, 10 gives `pulse_a`, 11 gives `pulse_b`. The three non-serial sources ignore `tx_inv` and appear one clock after they are sampled.
- R10: With `rx_dis`=0, `ser_rx` equals `rx_pin ^ rx_inv` as sampled two clock edges earlier, and `gpio_in` is 0.
- R11: With `rx_dis`=1, `ser_rx` is held at 1 and `gpio_in` carries the synchronized `rx_pin` with the same two-edge delay and no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brownout | input | 1 | Low-supply indication; suppresses the carrier |
| ser_tx | input | 1 | Serial transmit data from the serial transmitter |
| gpio_out | input | 1 | General-purpose output value for the transmit pin |
| pulse_a | input | 1 | First pulse source for the transmit pin |
| pulse_b | input | 1 | Second pulse source for the transmit pin |
| mod_en | input | 1 | Carrier modulation enable |
| duty_sel | input | 2 | Carrier low-time select |
| tx_inv | input | 1 | Invert the optical serial output |
| tx_sel | input | 2 | Transmit pin function select |
| rx_inv | input | 1 | Invert the received serial data |
| rx_dis | input | 1 | Release the receive pin as a general-purpose input |
| rx_pin | input | 1 | Receive pin level |
| tx_pin | output | 1 | Registered transmit pin drive |
| ser_rx | output | 1 | Received serial data for the serial receiver |
| gpio_in | output | 1 | General-purpose input value taken from the receive pin |

## Verification
The assertions assume that the configuration bits and the data sources change only between clock edges and stay steady for a full cycle. They also assume that the receive pin settles before the synchronizer samples it, so that its two-edge delay can be checked exactly. The bench drives every input on the falling clock edge and keeps each setting for at least one whole cycle, which satisfies both assumptions. It changes `duty_sel` only while a carrier is already running, because the requirements let the new low length take effect at the current phase, and the reference model tracks the phase under the same rule.

// File: rtl/optport_pkg.sv
package optport_pkg;

  // Transmit pin function codes (tx_sel)
  typedef enum logic [1:0] {
    TXF_SERIAL  = 2'b00,
    TXF_GPIO    = 2'b01,
    TXF_PULSE_A = 2'b10,
    TXF_PULSE_B = 2'b11
  } txfn_e;

  // Carrier low-time codes (duty_sel)
  typedef enum logic [1:0] {
    DUTY_HALF      = 2'b00,
    DUTY_QUARTER   = 2'b01,
    DUTY_EIGHTH    = 2'b10,
    DUTY_SIXTEENTH = 2'b11
  } duty_e;

endpackage

// File: rtl/optport_carrier.sv
module optport_carrier
  import optport_pkg::*;
#(
  parameter int PERIOD_CYC = 1315
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] duty_sel,
  output logic       burst_low
);

  localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_2  = CNT_W'(PERIOD_CYC >> 1);
  localparam logic [CNT_W-1:0] LOW_4  = CNT_W'(PERIOD_CYC >> 2);
  localparam logic [CNT_W-1:0] LOW_8  = CNT_W'(PERIOD_CYC >> 3);
  localparam logic [CNT_W-1:0] LOW_16 = CNT_W'(PERIOD_CYC >> 4);

  logic [CNT_W-1:0] phase_q, phase_d;
  logic [CNT_W-1:0] low_len;

  always_comb begin
    case (duty_e'(duty_sel))
      DUTY_HALF:    low_len = LOW_2;
      DUTY_QUARTER: low_len = LOW_4;
      DUTY_EIGHTH:  low_len = LOW_8;
      default:      low_len = LOW_16;
    endcase
  end

  // Phase restarts whenever the carrier is not running
  always_comb begin
    if (!run)                phase_d = '0;
    else if (phase_q == LAST) phase_d = '0;
    else                      phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign burst_low = run && (phase_q < low_len);

endmodule

// File: rtl/optport_txpath.sv
module optport_txpath
  import optport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       burst_low,
  input  logic       ser_tx,
  input  logic       tx_inv,
  input  logic [1:0] tx_sel,
  input  logic       gpio_out,
  input  logic       pulse_a,
  input  logic       pulse_b,
  output logic       tx_pin
);

  logic shaped;
  logic opt_bit;
  logic pin_d, pin_q;

  // Data high holds idle; data low lets the carrier through
  always_comb begin
    if (run) shaped = ser_tx | ~burst_low;
    else     shaped = ser_tx;
    opt_bit = shaped ^ tx_inv;
  end

  always_comb begin
    case (txfn_e'(tx_sel))
      TXF_SERIAL:  pin_d = opt_bit;
      TXF_GPIO:    pin_d = gpio_out;
      TXF_PULSE_A: pin_d = pulse_a;
      default:     pin_d = pulse_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_d;
  end

  assign tx_pin = pin_q;

endmodule

// File: rtl/optport_rxpath.sv
module optport_rxpath #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic rx_inv,
  input  logic rx_dis,
  output logic ser_rx,
  output logic gpio_in
);

  logic [SYNC_STAGES-1:0] sync_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      logic stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = rx_pin;
      end else begin : g_next
        assign stage_d = sync_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[gi] <= 1'b1;
        else        sync_q[gi] <= stage_d;
      end
    end
  endgenerate

  logic rx_sync;
  assign rx_sync = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (rx_dis) begin
      ser_rx  = 1'b1;
      gpio_in = rx_sync;
    end else begin
      ser_rx  = rx_sync ^ rx_inv;
      gpio_in = 1'b0;
    end
  end

endmodule

// File: rtl/optport_mod.sv
module optport_mod
  import optport_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int CARRIER_HZ  = 38_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brownout,
  input  logic       ser_tx,
  input  logic       gpio_out,
  input  logic       pulse_a,
  input  logic       pulse_b,
  input  logic       mod_en,
  input  logic [1:0] duty_sel,
  input  logic       tx_inv,
  input  logic [1:0] tx_sel,
  input  logic       rx_inv,
  input  logic       rx_dis,
  input  logic       rx_pin,
  output logic       tx_pin,
  output logic       ser_rx,
  output logic       gpio_in
);

  localparam int PERIOD_CYC = CLK_HZ / CARRIER_HZ;

  logic run;
  logic burst_low;

  assign run = mod_en & ~brownout;

  optport_carrier #(.PERIOD_CYC(PERIOD_CYC)) u_carrier (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .duty_sel  (duty_sel),
    .burst_low (burst_low)
  );

  optport_txpath u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .burst_low (burst_low),
    .ser_tx    (ser_tx),
    .tx_inv    (tx_inv),
    .tx_sel    (tx_sel),
    .gpio_out  (gpio_out),
    .pulse_a   (pulse_a),
    .pulse_b   (pulse_b),
    .tx_pin    (tx_pin)
  );

  optport_rxpath #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_pin  (rx_pin),
    .rx_inv  (rx_inv),
    .rx_dis  (rx_dis),
    .ser_rx  (ser_rx),
    .gpio_in (gpio_in)
  );

endmodule

// File: rtl/optport_mod_chk.sv
module optport_mod_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       brownout,
  input logic       ser_tx,
  input logic       gpio_out,
  input logic       pulse_a,
  input logic       pulse_b,
  input logic       mod_en,
  input logic       tx_inv,
  input logic [1:0] tx_sel,
  input logic       rx_inv,
  input logic       rx_dis,
  input logic       rx_pin,
  input logic       tx_pin,
  input logic       ser_rx,
  input logic       gpio_in
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  unmod_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && tx_sel == 2'b00) |=> (tx_pin == $past(ser_tx ^ tx_inv)));

  // R6
  brownout_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brownout && tx_sel == 2'b00) |=> (tx_pin == $past(ser_tx ^ tx_inv)));

  // R5
  data_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == 2'b00 && ser_tx && !tx_inv) |=> tx_pin);

  // R9
  gpio_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == 2'b01) |=> (tx_pin == $past(gpio_out)));

  // R9
  pulse_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel[1]) |=> (tx_pin == $past(tx_sel[0] ? pulse_b : pulse_a)));

  // R11
  rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dis |-> (ser_rx && $countones({gpio_in, 1'b0}) <= 1));

  // R10
  rx_gpio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dis |-> !gpio_in);

  generate
    if (SYNC_STAGES == 2) begin : g_rx_delay
      // R10
      rx_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !rx_dis) |-> (ser_rx == ($past(rx_pin, 2) ^ rx_inv)));
    end
  endgenerate

endmodule

bind optport_mod optport_mod_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .brownout (brownout),
  .ser_tx   (ser_tx),
  .gpio_out (gpio_out),
  .pulse_a  (pulse_a),
  .pulse_b  (pulse_b),
  .mod_en   (mod_en),
  .tx_inv   (tx_inv),
  .tx_sel   (tx_sel),
  .rx_inv   (rx_inv),
  .rx_dis   (rx_dis),
  .rx_pin   (rx_pin),
  .tx_pin   (tx_pin),
  .ser_rx   (ser_rx),
  .gpio_in  (gpio_in)
);

// File: tb/optport_mod_tb.sv
module optport_mod_tb;

  localparam int CARRIER = 38_000;
  localparam int P       = 32;
  localparam int CLKHZ   = P * CARRIER;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic rst_n;
  logic brownout, ser_tx, gpio_out, pulse_a, pulse_b, mod_en, tx_inv, rx_inv, rx_dis, rx_pin;
  logic [1:0] duty_sel, tx_sel;
  logic tx_pin, ser_rx, gpio_in;

  // next-cycle stimulus set by the sequence
  logic n_bo, n_stx, n_gpo, n_pa, n_pb, n_men, n_tinv, n_rinv, n_rdis, n_rxp;
  logic [1:0] n_duty, n_sel;

  optport_mod #(.CLK_HZ(CLKHZ), .CARRIER_HZ(CARRIER), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .brownout(brownout), .ser_tx(ser_tx),
    .gpio_out(gpio_out), .pulse_a(pulse_a), .pulse_b(pulse_b),
    .mod_en(mod_en), .duty_sel(duty_sel), .tx_inv(tx_inv), .tx_sel(tx_sel),
    .rx_inv(rx_inv), .rx_dis(rx_dis), .rx_pin(rx_pin),
    .tx_pin(tx_pin), .ser_rx(ser_rx), .gpio_in(gpio_in)
  );

  typedef struct {
    logic  tx;
    logic  srx;
    logic  gin;
    string tag;
  } item_t;

  item_t q[$];
  int nvec = 0;
  int nmis = 0;
  int ph = 0;
  logic rx_prev = 1'b1;
  bit done = 0;

  // Driver: apply next values at the falling edge and push the expectation
  task automatic step(input string tag);
    item_t it;
    logic low, opt;
    int len;
    @(negedge clk);
    brownout = n_bo; ser_tx = n_stx; gpio_out = n_gpo; pulse_a = n_pa; pulse_b = n_pb;
    mod_en = n_men; duty_sel = n_duty; tx_inv = n_tinv; tx_sel = n_sel;
    rx_inv = n_rinv; rx_dis = n_rdis; rx_pin = n_rxp;
    len = P >> (int'(duty_sel) + 1);
    if (mod_en && !brownout) begin
      low = (ph < len);
      ph  = (ph + 1) % P;
      opt = ser_tx ? 1'b1 : ~low;
    end else begin
      ph  = 0;
      opt = ser_tx;
    end
    opt = opt ^ tx_inv;
    case (tx_sel)
      2'b00:   it.tx = opt;
      2'b01:   it.tx = gpio_out;
      2'b10:   it.tx = pulse_a;
      default: it.tx = pulse_b;
    endcase
    it.srx = rx_dis ? 1'b1 : (rx_prev ^ rx_inv);
    it.gin = rx_dis ? rx_prev : 1'b0;
    rx_prev = rx_pin;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      nvec++;
      if (tx_pin !== it.tx || ser_rx !== it.srx || gpio_in !== it.gin) begin
        nmis++;
        $display("FAIL %s: tx_pin=%b ser_rx=%b gpio_in=%b expected %b %b %b",
                 it.tag, tx_pin, ser_rx, gpio_in, it.tx, it.srx, it.gin);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    n_bo = 0; n_stx = 1; n_gpo = 0; n_pa = 0; n_pb = 0; n_men = 0; n_tinv = 0;
    n_rinv = 0; n_rdis = 0; n_rxp = 1; n_duty = 2'b00; n_sel = 2'b00;
    brownout = 0; ser_tx = 1; gpio_out = 0; pulse_a = 0; pulse_b = 0; mod_en = 0;
    duty_sel = 0; tx_inv = 0; tx_sel = 0; rx_inv = 0; rx_dis = 0; rx_pin = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    nvec++;
    if (tx_pin !== 1'b1 || ser_rx !== 1'b1) begin
      nmis++;
      $display("FAIL R1: tx_pin=%b ser_rx=%b expected 1 1", tx_pin, ser_rx);
    end
    rst_n = 1'b1;
    step("R1");

    // R2 plain pass-through, data pattern
    for (int i = 0; i < 10; i++) begin n_stx = i[0] ^ i[2]; step("R2"); end
    n_tinv = 1;
    for (int i = 0; i < 6; i++) begin n_stx = i[1]; step("R8"); end
    n_tinv = 0;

    // R7 R3 R4 enable, half duty, data low
    n_stx = 0; n_men = 1; n_duty = 2'b00;
    run_n(2 * P, "R3");
    n_duty = 2'b01; run_n(P, "R4");
    n_duty = 2'b10; run_n(P, "R4");
    n_duty = 2'b11; run_n(P, "R4");
    // R7 restart: disable mid period then re-enable
    n_duty = 2'b01; run_n(5, "R7");
    n_men = 0; run_n(3, "R7");
    n_men = 1; run_n(P, "R7");

    // R5 data high holds idle; mixed bits
    n_stx = 1; run_n(10, "R5");
    for (int i = 0; i < 3 * P; i++) begin n_stx = (i / 7) % 2 == 1; step("R5"); end

    // R8 inversion after modulation
    n_tinv = 1; n_stx = 0; n_duty = 2'b10; run_n(P + 4, "R8");
    n_tinv = 0;

    // R6 brownout suppresses, then recovers with fresh phase
    n_bo = 1;
    for (int i = 0; i < 12; i++) begin n_stx = i[1]; step("R6"); end
    n_stx = 0; run_n(4, "R6");
    n_bo = 0; run_n(P, "R6");

    // R9 pin function select, inversion ignored
    n_tinv = 1;
    for (int s = 1; s < 4; s++) begin
      n_sel = 2'(s);
      for (int i = 0; i < 8; i++) begin
        n_gpo = i[0]; n_pa = i[1]; n_pb = i[0] ^ i[1] ^ i[2];
        step("R9");
      end
    end
    n_sel = 2'b00; n_tinv = 0; n_men = 0; n_stx = 1;

    // R10 receive path with both polarities
    for (int i = 0; i < 12; i++) begin n_rxp = i[0] ^ i[3]; step("R10"); end
    n_rinv = 1;
    for (int i = 0; i < 12; i++) begin n_rxp = i[1]; step("R10"); end
    // R11 receive pin released
    n_rdis = 1;
    for (int i = 0; i < 12; i++) begin n_rxp = i[0] | i[2]; step("R11"); end
    n_rdis = 0; n_rinv = 0; run_n(3, "R10");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nmis++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

endmodule